// File: doc/BRIEF.md
# Bus-Qualified Chip-Select Decoder

This block produces the chip-select signals for a small 8-bit processor board that has a 16-bit address bus. It turns each address into one of the following: a RAM region, one of three 2 KB I/O windows, or nothing. The three I/O windows serve a character display, a timer/interface chip and a versatile interface chip. The block is purely combinational, so every output follows its inputs within the same cycle.

The RAM covers the whole lower half of the map. It also covers the top quarter, which maps onto the upper 16 KB of the RAM. The quarter in between (0x8000–0xBFFF) is divided into eight 2 KB I/O blocks, and only the first three of them lead to a device.

A bus-enable input hands the RAM to an external loader. While bus-enable is high, the processor owns the bus. In that state the RAM enable is qualified by clock phase 1 being low, and the display enable is qualified by phase 2 being high. While bus-enable is low, the RAM enable simply copies the loader's own chip-enable, and every peripheral select is held off. The interface chips do their own phase-2 qualification internally, so their selects are not gated by the clock.

Top module: `addr_decoder`

## Requirements
- R1: With bus_en=1 and phi1=0, any address with bit 15 = 0 (0x0000–0x7FFF) drives ram_ce_n=0.
- R2: With bus_en=1 and phi1=0, any address with bits 15:14 = 11 (0xC000–0xFFFF) drives ram_ce_n=0.
- R3: With bus_en=1, ram_ce_n is 1 whenever phi1=1 or the address is in 0x8000–0xBFFF.
- R4: With bus_en=0, ram_ce_n equals ldr_ce_n for every address and clock phase.
- R5: disp_en (active high) is 1 exactly when bus_en=1, phi2=1, phi1=0 and the address is in 0x8000–0x87FF (bits 15:11 = 10000).
- R6: With bus_en=1, tmr_cs_n (active low) is 0 exactly for addresses 0x8800–0x8FFF (bits 15:11 = 10001), whatever the clock phase.
- R7: With bus_en=1, via_cs_n (active low) is 0 exactly for addresses 0x9000–0x97FF (bits 15:11 = 10010), whatever the clock phase.
- R8: Addresses 0x9800–0xBFFF assert no select: ram_ce_n=1, disp_en=0, tmr_cs_n=1, via_cs_n=1.
- R9: With bus_en=0, disp_en=0, tmr_cs_n=1 and via_cs_n=1 for every address.
- R10: For every combination of inputs, at most one of the four selects is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 16 | Address bus |
| phi1 | input | 1 | Clock phase 1 (high during the address phase) |
| phi2 | input | 1 | Clock phase 2 (high during the data phase) |
| bus_en | input | 1 | 1 = processor owns the bus, 0 = loader owns it |
| ldr_ce_n | input | 1 | Loader's active-low RAM chip-enable |
| ram_ce_n | output | 1 | Active-low RAM chip-enable |
| disp_en | output | 1 | Active-high display enable |
| tmr_cs_n | output | 1 | Active-low timer/interface chip select |
| via_cs_n | output | 1 | Active-low versatile interface chip select |

## Verification
The bench builds the decoder with its default parameters: a 16-bit address, 2 KB I/O blocks, and device block indices 0, 1 and 2. At these values the whole address space is small enough to sweep. Every address is applied under both clock phases and both bus-enable states, with the loader enable toggling along the way, and each result is compared against an independent model of the map. This sweep reaches every boundary between the RAM halves and the eight I/O blocks, the loader handover, and the one-select-at-most rule. A short table of directed vectors then pins down the exact edge addresses, as well as phase combinations in which the two phase inputs are not complementary.

// File: rtl/addr_decoder_pkg.sv
package addr_decoder_pkg;

  // Hit flags from the address decode, before any bus or clock qualification.
  typedef struct packed {
    logic ram;
    logic disp;
    logic tmr;
    logic via;
  } dev_hits_t;

endpackage

// File: rtl/region_decode.sv
module region_decode
  import addr_decoder_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int IO_BLK_W  = 11,
  parameter int DISP_BLK  = 0,
  parameter int TMR_BLK   = 1,
  parameter int VIA_BLK   = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output dev_hits_t         hits
);

  // The I/O quarter sits below the top two address bits.
  localparam int IDX_W   = ADDR_W - 2 - IO_BLK_W;
  localparam int NUM_BLK = 1 << IDX_W;

  logic               io_win;
  logic [IDX_W-1:0]   blk_idx;
  logic [NUM_BLK-1:0] blk_hit;
  logic               unused_low;

  assign io_win     = (addr[ADDR_W-1:ADDR_W-2] == 2'b10);
  assign blk_idx    = addr[ADDR_W-3:IO_BLK_W];
  assign unused_low = ^addr[IO_BLK_W-1:0];

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    assign blk_hit[b] = io_win && (blk_idx == IDX_W'(b));
  end

  always_comb begin
    hits.ram  = !addr[ADDR_W-1] || (addr[ADDR_W-1:ADDR_W-2] == 2'b11);
    hits.disp = blk_hit[DISP_BLK];
    hits.tmr  = blk_hit[TMR_BLK];
    hits.via  = blk_hit[VIA_BLK];
  end

endmodule

// File: rtl/ram_ce_mux.sv
module ram_ce_mux (
  input  logic ram_hit,
  input  logic phi1,
  input  logic bus_en,
  input  logic ldr_ce_n,
  output logic ram_ce_n
);

  logic cpu_ce_n;

  // Processor side: RAM only enabled outside phase 1.
  assign cpu_ce_n = !(ram_hit && !phi1);
  assign ram_ce_n = bus_en ? cpu_ce_n : ldr_ce_n;

endmodule

// File: rtl/periph_qualify.sv
module periph_qualify
  import addr_decoder_pkg::*;
(
  input  dev_hits_t hits,
  input  logic      phi1,
  input  logic      phi2,
  input  logic      bus_en,
  output logic      disp_en,
  output logic      tmr_cs_n,
  output logic      via_cs_n
);

  logic data_phase;
  logic unused_ram;

  assign data_phase = phi2 && !phi1;
  assign unused_ram = hits.ram;

  // Display latches on its own enable, so it gets the data phase here;
  // the interface chips see phase 2 themselves.
  assign disp_en  = bus_en && hits.disp && data_phase;
  assign tmr_cs_n = !(bus_en && hits.tmr);
  assign via_cs_n = !(bus_en && hits.via);

endmodule

// File: rtl/addr_decoder.sv
module addr_decoder
  import addr_decoder_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int IO_BLK_W  = 11,
  parameter int DISP_BLK  = 0,
  parameter int TMR_BLK   = 1,
  parameter int VIA_BLK   = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              phi1,
  input  logic              phi2,
  input  logic              bus_en,
  input  logic              ldr_ce_n,
  output logic              ram_ce_n,
  output logic              disp_en,
  output logic              tmr_cs_n,
  output logic              via_cs_n
);

  dev_hits_t hits;

  region_decode #(
    .ADDR_W  (ADDR_W),
    .IO_BLK_W(IO_BLK_W),
    .DISP_BLK(DISP_BLK),
    .TMR_BLK (TMR_BLK),
    .VIA_BLK (VIA_BLK)
  ) i_region (
    .addr(addr),
    .hits(hits)
  );

  ram_ce_mux i_ram (
    .ram_hit (hits.ram),
    .phi1    (phi1),
    .bus_en  (bus_en),
    .ldr_ce_n(ldr_ce_n),
    .ram_ce_n(ram_ce_n)
  );

  periph_qualify i_periph (
    .hits    (hits),
    .phi1    (phi1),
    .phi2    (phi2),
    .bus_en  (bus_en),
    .disp_en (disp_en),
    .tmr_cs_n(tmr_cs_n),
    .via_cs_n(via_cs_n)
  );

endmodule

// File: rtl/addr_decoder_chk.sv
module addr_decoder_chk #(
  parameter int ADDR_W    = 16,
  parameter int IO_BLK_W  = 11,
  parameter int DISP_BLK  = 0
) (
  input logic [ADDR_W-1:0] addr,
  input logic              phi1,
  input logic              phi2,
  input logic              bus_en,
  input logic              ldr_ce_n,
  input logic              ram_ce_n,
  input logic              disp_en,
  input logic              tmr_cs_n,
  input logic              via_cs_n
);

  localparam int TAG_W = ADDR_W - IO_BLK_W;

  logic [TAG_W-1:0] tag;
  logic             disp_addr;
  assign tag       = addr[ADDR_W-1:IO_BLK_W];
  assign disp_addr = (tag == TAG_W'((2 << (ADDR_W - 2 - IO_BLK_W)) + DISP_BLK));

  always_comb begin
    assert_one_select_R10: assert ($countones({!ram_ce_n, disp_en, !tmr_cs_n, !via_cs_n}) <= 1)
      else $error("more than one select active");
    if (!bus_en) begin
      assert_loader_ce_R4: assert (ram_ce_n == ldr_ce_n)
        else $error("RAM enable does not follow loader");
      assert_periph_off_R9: assert (!disp_en && tmr_cs_n && via_cs_n)
        else $error("peripheral selected while loader owns bus");
    end
    if (bus_en && phi1) begin
      assert_phase1_ram_off_R3: assert (ram_ce_n)
        else $error("RAM enabled in phase 1");
    end
    if (bus_en && !phi1 && !addr[ADDR_W-1]) begin
      assert_low_ram_R1: assert (!ram_ce_n)
        else $error("low RAM not enabled");
    end
    if (disp_en) begin
      assert_disp_qual_R5: assert (phi2 && !phi1 && bus_en && disp_addr)
        else $error("display enable outside its window");
    end
  end

endmodule

bind addr_decoder addr_decoder_chk #(
  .ADDR_W  (ADDR_W),
  .IO_BLK_W(IO_BLK_W),
  .DISP_BLK(DISP_BLK)
) i_chk (
  .addr    (addr),
  .phi1    (phi1),
  .phi2    (phi2),
  .bus_en  (bus_en),
  .ldr_ce_n(ldr_ce_n),
  .ram_ce_n(ram_ce_n),
  .disp_en (disp_en),
  .tmr_cs_n(tmr_cs_n),
  .via_cs_n(via_cs_n)
);

// File: tb/test_addr_decoder.sv
module test_addr_decoder;

  logic        clk = 1'b0;
  logic [15:0] addr = '0;
  logic        phi1 = 1'b1;
  logic        phi2 = 1'b0;
  logic        bus_en = 1'b1;
  logic        ldr_ce_n = 1'b1;
  logic        ram_ce_n, disp_en, tmr_cs_n, via_cs_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  addr_decoder i_addr_decoder (
    .addr    (addr),
    .phi1    (phi1),
    .phi2    (phi2),
    .bus_en  (bus_en),
    .ldr_ce_n(ldr_ce_n),
    .ram_ce_n(ram_ce_n),
    .disp_en (disp_en),
    .tmr_cs_n(tmr_cs_n),
    .via_cs_n(via_cs_n)
  );

  // Vector: {addr, phi1, phi2, bus_en, ldr_ce_n, ram_ce_n, disp_en, tmr_cs_n, via_cs_n}
  localparam int NV = 16;
  localparam logic [23:0] VEC [NV] = '{
    {16'h0000, 4'b0110, 4'b0011},  // R1 bottom of RAM
    {16'h7FFF, 4'b0110, 4'b0011},  // R1 top of low RAM
    {16'h7FFF, 4'b1010, 4'b1011},  // R3 phase 1 blocks RAM
    {16'hC000, 4'b0110, 4'b0011},  // R2 start of high RAM
    {16'hFFFF, 4'b0111, 4'b0011},  // R2 top of map
    {16'h8000, 4'b0110, 4'b1111},  // R5 display in data phase
    {16'h87FF, 4'b1010, 4'b1011},  // R5 display off in phase 1
    {16'h87FF, 4'b0010, 4'b1011},  // R5 both phases low: display off
    {16'h8800, 4'b1010, 4'b1001},  // R6 timer start, phase 1
    {16'h8FFF, 4'b0110, 4'b1001},  // R6 timer end, phase 2
    {16'h9000, 4'b1010, 4'b1010},  // R7 via start
    {16'h97FF, 4'b0110, 4'b1010},  // R7 via end
    {16'h9800, 4'b0110, 4'b1011},  // R8 first unused block
    {16'hBFFF, 4'b0110, 4'b1011},  // R8 last unused block
    {16'h8800, 4'b0100, 4'b0011},  // R4 R9 loader enables, timer off
    {16'h4000, 4'b0101, 4'b1011}   // R4 loader idle
  };

  function automatic logic [3:0] model(input logic [15:0] a, input logic p1, input logic p2,
                                       input logic be, input logic lc);
    logic ram, disp, tmr, via;
    ram  = (a < 16'h8000) || (a >= 16'hC000);
    disp = (a >= 16'h8000) && (a < 16'h8800);
    tmr  = (a >= 16'h8800) && (a < 16'h9000);
    via  = (a >= 16'h9000) && (a < 16'h9800);
    if (!be) return {lc, 1'b0, 1'b1, 1'b1};
    return {!(ram && !p1), disp && p2 && !p1, !tmr, !via};
  endfunction

  function automatic string req_of(input logic [15:0] a, input logic be);
    if (!be) return "R4/R9";
    if (a < 16'h8000) return "R1/R3";
    if (a >= 16'hC000) return "R2/R3";
    if (a < 16'h8800) return "R5";
    if (a < 16'h9000) return "R6";
    if (a < 16'h9800) return "R7";
    return "R8";
  endfunction

  task automatic check_now(input logic [3:0] exp, input string req);
    logic [3:0] act;
    act = {ram_ce_n, disp_en, tmr_cs_n, via_cs_n};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h phi1=%b phi2=%b be=%b ldr=%b actual=%b expected=%b",
               req, addr, phi1, phi2, bus_en, ldr_ce_n, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] act;
    int         n_act;
    // Idle state: phase 1, processor bus, address 0.
    #2;
    check_now(4'b1011, "R3");

    for (int i = 0; i < NV; i++) begin
      {addr, phi1, phi2, bus_en, ldr_ce_n} = VEC[i][23:4];
      #2;
      check_now(VEC[i][3:0], req_of(addr, bus_en));
    end

    // Full sweep: every address, both phases, both bus owners.
    for (int a = 0; a < 65536; a++) begin
      for (int m = 0; m < 4; m++) begin
        addr     = 16'(a);
        phi1     = m[0];
        phi2     = !m[0];
        bus_en   = m[1];
        ldr_ce_n = a[0] ^ m[0];
        #2;
        check_now(model(addr, phi1, phi2, bus_en, ldr_ce_n), req_of(addr, bus_en));
        act   = {!ram_ce_n, disp_en, !tmr_cs_n, !via_cs_n};
        n_act = $countones(act);
        if (a[7:0] == 8'h00 || n_act > 1) begin
          checks++;
          if (n_act > 1) begin
            errors++;
            $display("FAIL R10 addr=%h actual=%0d active expected<=1", addr, n_act);
          end
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule